// File: doc/BRIEF.md
# Configurable Bidirectional GPIO Port

This block controls an 8-bit general-purpose I/O port. Each pin has its own direction bit and a shared output data latch. It also has an active-low weak pull-up control, and a set of pins can share a global open-drain mode. A register bus writes four registers through separate write strobes: data, direction, pull-up and control. The bus reads back a mixed view of the port, where input pins show their synchronized pad level and output pins show the latch value.

The block also watches a configurable subset of the input pins for changes. Each monitored pin that is an input is compared against a snapshot taken on the last port read. Any difference sets a sticky request flag, and only a port read clears it. The flag is a register, so it is also presented as a wake output that holds steady while the core clock is stopped. When a pin is configured as an output, its pull-up and its change detection are switched off automatically.

Top module: `gpio_port`

## Requirements
- R1: After reset all pins are inputs (pad_oe = 0), every pull-up is off (pad_pu = 0), open-drain and change detection are disabled, and irq is 0.
- R2: A pulse on data_we loads wdata into the data latch. A pulse on dir_we loads wdata into the direction register, where bit value 1 means input and 0 means output. Both take effect on the next clock edge.
- R3: A pin whose direction bit is 1 never has pad_oe set. A pin whose direction bit is 0 drives pad_out from its data latch bit, unless R5 applies.
- R4: A pulse on pull_we loads wdata as active-low pull-up controls. pad_pu[i] is 1 exactly when control bit i is 0 and pin i is an input.
- R5: The control register is loaded by ctrl_we, with wdata[0] the open-drain enable and wdata[1] the active-low change-detect enable. When open-drain is enabled, each pin in OD_MASK (default bits 7 and 6) that is an output drives low for a latch value of 0 (pad_oe = 1, pad_out = 0) and releases for a 1 (pad_oe = 0). Pins outside OD_MASK are unaffected.
- R6: rdata bit i equals the pad level two clock edges earlier for an input pin, and the data latch bit for an output pin.
- R7: When change detection is enabled, a level change on a monitored input pin (MON_MASK, default bits 5..0) sets irq three clock edges after the pad changes.
- R8: Once set, irq stays set until a cycle with port_rd high. That read clears it and snapshots the synchronized pins.
- R9: irq is not set when change detection is disabled, when the changed pin is an output, or when the pin is outside MON_MASK.
- R10: If a change is already visible to the comparator in the cycle port_rd is high, the read wins: irq stays 0 and the change is absorbed into the new snapshot.
- R11: wake always equals irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 8 | Register write data |
| data_we | input | 1 | Data latch write strobe |
| dir_we | input | 1 | Direction register write strobe |
| pull_we | input | 1 | Pull-up control write strobe |
| ctrl_we | input | 1 | Control register write strobe |
| port_rd | input | 1 | Port read strobe (snapshot, clear flag) |
| rdata | output | 8 | Port read value |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad weak pull-up enables |
| irq | output | 1 | Sticky change interrupt request |
| wake | output | 1 | Wake request, registered copy of the flag |

## Verification
A pin change and a port read can fall in the same cycle: the comparator already sees a mismatch just as the read strobe arrives. The bench provokes this by toggling a monitored pin, waiting the two synchronizer edges, and then raising port_rd for exactly the cycle in which the flag would otherwise be set. It judges the outcome by requiring irq to stay low both right after that edge and several cycles later, and by requiring rdata to already show the new pin level. A second coincidence, a change arriving while detection is being disabled, is covered by checking that the flag never rises without the enable having been active one cycle before.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Open-drain release: an output pin in open-drain mode stops driving for a 1.
  function automatic logic od_release(input logic od_capable, input logic od_on,
                                      input logic latch_bit);
    return od_capable & od_on & latch_bit;
  endfunction

  // Output enable for one pin (dir bit 1 = input).
  function automatic logic pin_oe(input logic dir_bit, input logic release_bit);
    return ~dir_bit & ~release_bit;
  endfunction

  // Read view of one pin.
  function automatic logic pin_view(input logic dir_bit, input logic sync_bit,
                                    input logic latch_bit);
    return dir_bit ? sync_bit : latch_bit;
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wdata,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         pull_we,
  input  logic         ctrl_we,
  output logic [N-1:0] data_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] pull_n_q,
  output logic         od_en_q,
  output logic         chg_en_n_q
);
  localparam int CTRL_OD  = 0;
  localparam int CTRL_CHG = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q     <= '0;
      dir_q      <= '1;
      pull_n_q   <= '1;
      od_en_q    <= 1'b0;
      chg_en_n_q <= 1'b1;
    end else begin
      if (data_we) data_q   <= wdata;
      if (dir_we)  dir_q    <= wdata;
      if (pull_we) pull_n_q <= wdata;
      if (ctrl_we) begin
        od_en_q    <= wdata[CTRL_OD];
        chg_en_n_q <= wdata[CTRL_CHG];
      end
    end
  end

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_we |=> dir_q == $past(wdata));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], async_in[i]};
    end
    assign sync_out[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_change.sv
module gpio_change #(
  parameter int           N        = 8,
  parameter logic [N-1:0] MON_MASK = 8'h3F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_sync,
  input  logic [N-1:0] dir_q,
  input  logic         chg_en_n,
  input  logic         port_rd,
  output logic [N-1:0] change_vec,
  output logic         flag_q
);
  logic [N-1:0] snap_q;
  logic         change_any;

  assign change_vec = (pin_sync ^ snap_q) & dir_q & MON_MASK & {N{~chg_en_n}};
  assign change_any = |change_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
      flag_q <= 1'b0;
    end else if (port_rd) begin
      snap_q <= pin_sync;
      flag_q <= 1'b0;
    end else if (change_any) begin
      flag_q <= 1'b1;
    end
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !port_rd) |=> flag_q);
  // R10
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_rd |=> !flag_q);
  // R9
  flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(!chg_en_n));
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad
  import gpio_pkg::*;
#(
  parameter int           N       = 8,
  parameter logic [N-1:0] OD_MASK = 8'hC0
) (
  input  logic [N-1:0] data_q,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] pull_n_q,
  input  logic         od_en_q,
  input  logic [N-1:0] pin_sync,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_pu,
  output logic [N-1:0] rdata
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic rel;
    assign rel       = od_release(OD_MASK[i], od_en_q, data_q[i]);
    assign pad_oe[i] = pin_oe(dir_q[i], rel);
    assign pad_out[i] = data_q[i] & ~rel;
    assign pad_pu[i] = ~pull_n_q[i] & dir_q[i];
    assign rdata[i]  = pin_view(dir_q[i], pin_sync[i], data_q[i]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int         N        = 8,
  parameter logic [7:0] OD_MASK  = 8'hC0,
  parameter logic [7:0] MON_MASK = 8'h3F
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wdata,
  input  logic         data_we,
  input  logic         dir_we,
  input  logic         pull_we,
  input  logic         ctrl_we,
  input  logic         port_rd,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] pad_in,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pad_pu,
  output logic         irq,
  output logic         wake
);
  localparam logic [N-1:0] ODM = N'(OD_MASK);
  localparam logic [N-1:0] MNM = N'(MON_MASK);

  logic [N-1:0] data_q, dir_q, pull_n_q, pin_sync, change_vec;
  logic         od_en_q, chg_en_n_q, flag_q;

  gpio_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .data_we(data_we), .dir_we(dir_we), .pull_we(pull_we), .ctrl_we(ctrl_we),
    .data_q(data_q), .dir_q(dir_q), .pull_n_q(pull_n_q),
    .od_en_q(od_en_q), .chg_en_n_q(chg_en_n_q)
  );

  gpio_sync #(.N(N), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_change #(.N(N), .MON_MASK(MNM)) u_chg (
    .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .dir_q(dir_q),
    .chg_en_n(chg_en_n_q), .port_rd(port_rd),
    .change_vec(change_vec), .flag_q(flag_q)
  );

  gpio_pad #(.N(N), .OD_MASK(ODM)) u_pad (
    .data_q(data_q), .dir_q(dir_q), .pull_n_q(pull_n_q), .od_en_q(od_en_q),
    .pin_sync(pin_sync), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .rdata(rdata)
  );

  assign irq  = flag_q;
  assign wake = flag_q;

  // R3
  input_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);
  // R4
  pull_out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & ~dir_q) == '0);
  // R5
  od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_en_q |-> (pad_oe & data_q & ODM) == '0);
  // R9
  out_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (change_vec & ~dir_q) == '0);
  // R11
  wake_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake == irq);
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wdata = '0;
  logic       data_we = 0, dir_we = 0, pull_we = 0, ctrl_we = 0, port_rd = 0;
  logic [7:0] pad_in = '0;
  logic [7:0] rdata, pad_out, pad_oe, pad_pu;
  logic       irq, wake;
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [7:0] OD_SET  = 8'hC0;
  localparam logic [7:0] MON_SET = 8'h3F;

  logic [7:0] m_data = 8'h00, m_dir = 8'hFF, m_pull_n = 8'hFF;
  logic       m_od = 0;

  always #10 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .data_we(data_we), .dir_we(dir_we),
    .pull_we(pull_we), .ctrl_we(ctrl_we), .port_rd(port_rd), .rdata(rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .irq(irq), .wake(wake)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int which, input logic [7:0] v);
    wdata = v;
    case (which)
      0: begin data_we = 1; m_data = v; end
      1: begin dir_we = 1; m_dir = v; end
      2: begin pull_we = 1; m_pull_n = v; end
      default: begin ctrl_we = 1; m_od = v[0]; end
    endcase
    tick(1);
    data_we = 0; dir_we = 0; pull_we = 0; ctrl_we = 0;
  endtask

  task automatic rd();
    port_rd = 1; tick(1); port_rd = 0;
  endtask

  // Independent expectations, computed per pin.
  task automatic check_pads(input string tag);
    logic [7:0] e_oe, e_out, e_pu, e_rd;
    for (int i = 0; i < 8; i++) begin
      logic drives_high_released;
      drives_high_released = m_od && OD_SET[i] && m_data[i];
      e_oe[i]  = (m_dir[i] == 1'b0) && !drives_high_released;
      e_out[i] = drives_high_released ? 1'b0 : m_data[i];
      e_pu[i]  = (m_pull_n[i] == 1'b0) && (m_dir[i] == 1'b1);
      e_rd[i]  = m_dir[i] ? pad_in[i] : m_data[i];
    end
    chk({tag, " R3/R5 oe"}, pad_oe, e_oe);
    chk({tag, " R2/R5 out"}, pad_out, e_out);
    chk({tag, " R4 pu"}, pad_pu, e_pu);
    chk({tag, " R6 rdata"}, rdata, e_rd);
    chk({tag, " R11 wake"}, {7'd0, wake}, {7'd0, irq});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] dirs [5];
    dirs = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h0F};
    tick(2);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 R3 R4 R5 R6 sweeps over data for several direction patterns
    for (int od = 0; od < 2; od++) begin
      wr(3, {6'd0, 1'b1, od[0]});
      for (int d = 0; d < 5; d++) begin
        wr(1, dirs[d]);
        wr(2, dirs[(d + 2) % 5] ^ 8'h5A);
        pad_in = ~dirs[d] ^ 8'h33;
        tick(2);
        for (int v = 0; v < 256; v++) begin
          wr(0, v[7:0]);
          check_pads(od ? "od" : "pp");
        end
      end
    end

    // R7 R8 change detection on each pin
    wr(3, 8'h00);
    wr(1, 8'hFF);
    pad_in = 8'h00;
    tick(3);
    rd();
    tick(1);
    chk("R8 clear after snap", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 8; i++) begin
      pad_in[i] = ~pad_in[i];
      tick(2);
      chk("R7 not yet", {7'd0, irq}, 8'h00);
      tick(1);
      chk(MON_SET[i] ? "R7 set" : "R9 unmonitored", {7'd0, irq}, {7'd0, MON_SET[i]});
      tick(5);
      chk("R8 hold", {7'd0, irq}, {7'd0, MON_SET[i]});
      chk("R11 wake", {7'd0, wake}, {7'd0, MON_SET[i]});
      rd();
      chk("R8 read clears", {7'd0, irq}, 8'h00);
      tick(4);
      chk("R8 snapshot", {7'd0, irq}, 8'h00);
    end

    // R9 detection disabled
    wr(3, 8'h02);
    pad_in = pad_in ^ 8'h3F;
    tick(4);
    chk("R9 disabled", {7'd0, irq}, 8'h00);
    wr(3, 8'h00);
    rd();
    tick(1);
    // R9 output pins ignored
    wr(1, 8'hF0);
    pad_in = pad_in ^ 8'h0F;
    tick(4);
    chk("R9 output pin", {7'd0, irq}, 8'h00);
    wr(1, 8'hFF);
    tick(2);
    rd();
    tick(2);

    // R10 read coinciding with a visible change
    pad_in[2] = ~pad_in[2];
    tick(2);
    port_rd = 1; tick(1); port_rd = 0;
    chk("R10 read wins", {7'd0, irq}, 8'h00);
    chk("R10 rdata", rdata, pad_in);
    tick(4);
    chk("R10 absorbed", {7'd0, irq}, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule